// File: doc/BRIEF.md
# Serial Baud Rate Divider

This block produces the bit-rate timing for one serial channel. Software loads an 8-bit divide value `n` through a one-cycle write strobe. A down-counter then divides a count source by `n + 1` and emits a one-cycle baud tick. The count source depends on the mode:

- In asynchronous mode it is the `src_tick` enable, which comes from a source selector outside the block.
- In clocked-synchronous mode with an internal clock, it is the bus clock passed through a selectable prescaler. A toggle stage then halves the tick rate to give a 50 % duty shift clock on `sclk_out`.
- In clocked-synchronous mode with an external clock, the divider is idle. `sclk_out` follows a synchronized copy of `ext_sclk`.

A value written while the divider runs is staged in a pending register. The count in progress finishes on the old value, and the new value is used from the reload at the next terminal count. The divide value has no meaningful reset content. A valid flag, cleared by reset and set by the first write, keeps the divider silent until software has loaded a value. Dropping `enable` parks the counter, prescaler and toggle stage in their load state. Raising it again starts a full count.

All pins are plain control and status signals. The write port has no back-pressure: a strobe is always accepted in its cycle.

Top module: `baud_rate_divider`

## Requirements
- R1: In asynchronous mode (`mode` = 2'b00 or 2'b11) with a valid divide value `n`, the first `baud_tick` appears after `n+1` source ticks counted from the first clock edge with `enable` high. Each following tick comes after another `n+1` source ticks.
- R2: The divide value `n` = 0 gives a tick for every source tick. The value `n` = 255 gives one tick per 256 source ticks.
- R3: A divide value written while the divider runs does not change the count in progress. It sets the period from the reload that follows the next terminal count.
- R4: After reset, no `baud_tick` is produced until the divide value has been written at least once, whatever the other inputs do.
- R5: While `enable` is low, `baud_tick`, `sclk_out` and `sclk_rise` stay 0. When `enable` rises, the count restarts from the full value `n`.
- R6: In synchronous-internal mode (`mode` = 2'b01), `pre_sel` values 0, 1, 2 and 3 divide the bus clock by 1, 4, 16 and 64 before the divider. The tick period is therefore `(n+1)*ratio` clock cycles, and so is the latency from enable to the first tick.
- R7: In synchronous-internal mode, `sclk_out` starts at 0 and inverts at every `baud_tick`, so its period is twice the tick period. `sclk_rise` pulses for one cycle in the cycle where `sclk_out` turns from 0 to 1.
- R8: In synchronous-external mode (`mode` = 2'b10), `baud_tick` stays 0 and `sclk_out` copies `ext_sclk` two clock edges later. `sclk_rise` pulses in the cycle in which `sclk_out` becomes 1.
- R9: `baud_tick` is registered. It is high for exactly the one cycle after the clock edge at which the counter, holding zero, receives a source tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low parks the divider in its load state |
| mode | input | 2 | 00/11 asynchronous, 01 sync internal clock, 10 sync external clock |
| pre_sel | input | 2 | Prescaler ratio in sync internal mode: 1, 4, 16, 64 |
| src_tick | input | 1 | Count-source enable used in asynchronous mode |
| div_wr | input | 1 | Write strobe for the divide value |
| div_wdata | input | 8 | Divide value n (ratio n+1) |
| ext_sclk | input | 1 | External shift clock for sync external mode |
| baud_tick | output | 1 | One-cycle tick per completed divide |
| sclk_out | output | 1 | Shift clock (toggle output or synchronized external clock) |
| sclk_rise | output | 1 | One-cycle pulse on each rising shift-clock edge |

## Verification
With `enable` driven high just before clock edge k, the first `baud_tick` is due after edge k+(n+1)·ratio−1. It can be seen at the following falling edge. Each later tick comes (n+1)·ratio edges after the one before. `sclk_out` and `sclk_rise` change at the same edges as `baud_tick`. An external clock change made before edge a appears on `sclk_out` after edge a+1. The scoreboard records the expected number of edges between ticks, counts rising edges and compares at falling edges, so each result is sampled half a cycle after the edge that produces it.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC    = 2'b00,
    MODE_SYNC_INT = 2'b01,
    MODE_SYNC_EXT = 2'b10,
    MODE_ASYNC_B  = 2'b11
  } baud_mode_e;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             en
);
  localparam int unsigned N_SEL = 1 << SEL_W;
  localparam int unsigned PRE_W = STEP * (N_SEL - 1);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim [N_SEL];

  // terminal value per ratio: 4^g - 1
  for (genvar g = 0; g < N_SEL; g++) begin : g_lim
    assign lim[g] = PRE_W'((64'd1 << (g * STEP)) - 64'd1);
  end

  assign en = run & (cnt_q == lim[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (en)     cnt_q <= '0;
    else             cnt_q <= cnt_q + PRE_W'(1);
  end

  // R6: with a ratio above one, enables never come back to back
  assert_pre_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel != '0 && $stable(sel) && en) |=> !en);
endmodule

// File: rtl/baud_down_counter.sv
module baud_down_counter #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_en,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_val,
  output logic             armed,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] pend_q;
  logic             valid_q;

  assign armed = run & valid_q;
  assign tick  = armed & src_en & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
    end else if (wr_en) begin
      pend_q  <= wr_val;
      valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!armed)     cnt_q <= pend_q;
    else if (src_en)     cnt_q <= (cnt_q == '0) ? pend_q : cnt_q - ONE;
  end

  // R1: each source tick moves a nonzero count down by one
  assert_count_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && src_en && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

  // R3: terminal count reloads from the pending value seen at that edge
  assert_reload_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(pend_q));
endmodule

// File: rtl/baud_shift_clock.sv
module baud_shift_clock #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_run,
  input  logic adv,
  input  logic ext_run,
  input  logic ext_sclk,
  output logic sclk,
  output logic sclk_rise
);
  logic                   tog_q;
  logic                   int_rise_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_rise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q      <= 1'b0;
      int_rise_q <= 1'b0;
    end else if (!int_run) begin
      tog_q      <= 1'b0;
      int_rise_q <= 1'b0;
    end else begin
      if (adv) tog_q <= ~tog_q;
      int_rise_q <= adv & ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      ext_rise_q <= 1'b0;
    end else if (!ext_run) begin
      sync_q     <= '0;
      ext_rise_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_sclk};
      ext_rise_q <= sync_q[SYNC_STAGES-2] & ~sync_q[SYNC_STAGES-1];
    end
  end

  assign sclk      = ext_run ? sync_q[SYNC_STAGES-1] : tog_q;
  assign sclk_rise = ext_run ? ext_rise_q : int_rise_q;

  // R7/R8: a rising shift clock always comes with its rise pulse
  assert_rise_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ext_run) && $rose(sclk)) |-> sclk_rise);
endmodule

// File: rtl/baud_rate_divider.sv
module baud_rate_divider #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned PRE_STEP    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic [SEL_W-1:0] pre_sel,
  input  logic             src_tick,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             ext_sclk,
  output logic             baud_tick,
  output logic             sclk_out,
  output logic             sclk_rise
);
  import baud_div_pkg::*;

  baud_mode_e mode_e;
  logic       is_int, is_ext;
  logic       armed, tick_now, pre_en, src_en;
  logic       tick_q;

  assign mode_e = baud_mode_e'(mode);
  assign is_int = (mode_e == MODE_SYNC_INT);
  assign is_ext = (mode_e == MODE_SYNC_EXT);

  baud_prescaler #(.SEL_W(SEL_W), .STEP(PRE_STEP)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (armed & is_int),
    .sel   (pre_sel),
    .en    (pre_en)
  );

  assign src_en = is_int ? pre_en : src_tick;

  baud_down_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (enable & ~is_ext),
    .src_en (src_en),
    .wr_en  (div_wr),
    .wr_val (div_wdata),
    .armed  (armed),
    .tick   (tick_now)
  );

  baud_shift_clock #(.SYNC_STAGES(SYNC_STAGES)) u_sclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_run   (armed & is_int),
    .adv       (tick_now),
    .ext_run   (enable & is_ext),
    .ext_sclk  (ext_sclk),
    .sclk      (sclk_out),
    .sclk_rise (sclk_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_now;
  end

  assign baud_tick = tick_q;

  // R5: a tick needs enable high on the previous cycle
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !baud_tick);

  // R8: external-clock mode never ticks
  assert_ext_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ext && $past(is_ext)) |-> !baud_tick);

  // R7: the internal shift clock only moves together with a tick
  assert_sclk_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_int && $stable(mode) && enable && $past(enable) && !$stable(sclk_out))
      |-> baud_tick);
endmodule

// File: tb/baud_rate_divider_bench.sv
module baud_rate_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] pre_sel = 2'b00;
  logic       src_tick = 1'b1;
  logic       div_wr = 1'b0;
  logic [7:0] div_wdata = 8'd0;
  logic       ext_sclk = 1'b0;
  logic       baud_tick, sclk_out, sclk_rise;

  always #2 clk = ~clk;

  baud_rate_divider u_baud_rate_divider (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .pre_sel(pre_sel),
    .src_tick(src_tick), .div_wr(div_wr), .div_wdata(div_wdata), .ext_sclk(ext_sclk),
    .baud_tick(baud_tick), .sclk_out(sclk_out), .sclk_rise(sclk_rise)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    mon_on = 1'b0;
  bit    chk_sclk = 1'b0;
  bit    exp_sclk = 1'b0;
  int    since = 0;
  int    e_gap;
  string e_tag;
  int    seen;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: edges since the last reference point
  always @(posedge clk) if (mon_on) since++;

  always @(negedge clk) begin
    if (mon_on && baud_tick && exp_q.size() > 0) begin
      e_gap = exp_q.pop_front();
      e_tag = tag_q.pop_front();
      check(since == e_gap, e_tag, since, e_gap);
      since = 0;
      if (chk_sclk) begin
        exp_sclk = ~exp_sclk;
        check(sclk_out == exp_sclk, "R7 sclk_out level", int'(sclk_out), int'(exp_sclk));
        check(sclk_rise == exp_sclk, "R7 sclk_rise pulse", int'(sclk_rise), int'(exp_sclk));
      end
    end
  end

  task automatic write_div(input logic [7:0] v);
    @(negedge clk);
    div_wr = 1'b1; div_wdata = v;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 20000 && exp_q.size() > 0; i++) @(negedge clk);
    if (exp_q.size() > 0) begin
      check(1'b0, {tag, " ticks missing"}, exp_q.size(), 0);
      exp_q.delete(); tag_q.delete();
    end
    mon_on = 1'b0;
    enable = 1'b0;
  endtask

  task automatic push(input int gap, input string tag);
    exp_q.push_back(gap); tag_q.push_back(tag);
  endtask

  // driver: configure, push expected gaps, start
  task automatic run(input logic [1:0] m, input logic [1:0] s, input bit do_wr,
                     input logic [7:0] n, input int first, input int gap,
                     input int cnt, input string tag);
    @(negedge clk);
    enable = 1'b0; mode = m; pre_sel = s;
    if (do_wr) write_div(n);
    repeat (2) @(negedge clk);
    push(first, tag);
    for (int i = 1; i < cnt; i++) push(gap, tag);
    exp_sclk = 1'b0;
    chk_sclk = (m == 2'b01);
    since = 0;
    enable = 1'b1;
    mon_on = 1'b1;
    drain(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(baud_tick == 1'b0 && sclk_out == 1'b0 && sclk_rise == 1'b0,
          "R5 reset outputs", {baud_tick, sclk_out, sclk_rise}, 0);
    rst_n = 1'b1;

    // R4: enabled but never written -> silent
    @(negedge clk);
    enable = 1'b1; mode = 2'b00; src_tick = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (baud_tick) seen++; end
    check(seen == 0, "R4 no tick before first write", seen, 0);
    enable = 1'b0;

    // R1 / R9 async, n=3 -> period 4
    run(2'b00, 2'b00, 1'b1, 8'd3, 4, 4, 4, "R1 async n=3");
    // R2 extremes
    run(2'b00, 2'b00, 1'b1, 8'd0, 1, 1, 5, "R2 n=0");
    run(2'b11, 2'b00, 1'b1, 8'd255, 256, 256, 2, "R2 n=255");

    // R3: rewrite while running
    @(negedge clk);
    mode = 2'b00;
    write_div(8'd3);
    repeat (2) @(negedge clk);
    push(4, "R3 count in progress kept");
    push(2, "R3 new value after reload");
    push(2, "R3 new value after reload");
    since = 0; enable = 1'b1; mon_on = 1'b1;
    @(negedge clk);
    div_wr = 1'b1; div_wdata = 8'd1;
    @(negedge clk);
    div_wr = 1'b0;
    drain("R3");

    // R5: stop mid-count, restart from full count
    @(negedge clk);
    write_div(8'd5);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    seen = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (baud_tick) seen++; end
    check(seen == 0, "R5 no tick while disabled", seen, 0);
    run(2'b00, 2'b00, 1'b0, 8'd5, 6, 6, 2, "R5 restart full count");

    // R6 / R7 sync internal
    run(2'b01, 2'b00, 1'b1, 8'd2, 3, 3, 4, "R6 sel=0 n=2");
    run(2'b01, 2'b01, 1'b1, 8'd2, 12, 12, 3, "R6 sel=1 n=2");
    run(2'b01, 2'b10, 1'b1, 8'd0, 16, 16, 3, "R6 sel=2 n=0");
    run(2'b01, 2'b11, 1'b1, 8'd1, 128, 128, 2, "R6 sel=3 n=1");

    // R8 external clock
    @(negedge clk);
    mode = 2'b10; ext_sclk = 1'b0; enable = 1'b1;
    repeat (4) @(negedge clk);
    ext_sclk = 1'b1;
    @(negedge clk);
    check(sclk_out == 1'b0, "R8 one edge after change", int'(sclk_out), 0);
    @(negedge clk);
    check(sclk_out == 1'b1, "R8 follows after two edges", int'(sclk_out), 1);
    check(sclk_rise == 1'b1, "R8 rise pulse", int'(sclk_rise), 1);
    @(negedge clk);
    check(sclk_rise == 1'b0, "R8 rise one cycle", int'(sclk_rise), 0);
    ext_sclk = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk_out == 1'b0 && sclk_rise == 1'b0, "R8 falls after two edges",
          {sclk_out, sclk_rise}, 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ext_sclk = ~ext_sclk;
      if (baud_tick) seen++;
    end
    check(seen == 0, "R8 no baud tick in external mode", seen, 0);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk_out == 1'b0, "R5 sclk parked low", int'(sclk_out), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule